// File: doc/BRIEF.md
# Row-Latch Low-Energy Read Controller

This controller sits in front of a word-addressed memory of four banks, each holding 64 rows of 128 bits. Every row holds eight 16-bit words. The array has no column multiplexing, so any activation of a wordline moves a whole row. The controller keeps a copy of the most recently activated row in a 128-bit latch, together with a tag naming the bank and row it came from.

A read whose bank and row match the latched tag is a low-energy read. The bank decoder, the row decoder and the wordline stay idle, and the controller picks the word from the latch. A read that does not match is a full read. It activates one wordline, loads the latch and tag, and returns the word from the row that was just read. No external hint is needed: hits are found by comparing tags, so eight consecutive words of one row cost one activation.

Writes are single-cycle read-modify-write operations on the full row. When a write lands in the latched row, the latch is updated as well. A power-down request drops the latch contents. Each accepted read gives a one-cycle completion pulse and a flag that tells full reads apart from low-energy reads.

Top module: `rowlatch_rd_ctrl`

## Requirements
- R1: After reset, `rd_done`, `rd_full` and `rdata` are 0 and the latch is empty, so the first read is a full read.
- R2: A read whose bank and row differ from the latched tag (or any read while the latch is empty) fires one wordline. One cycle later it returns the stored word with `rd_done`=1 and `rd_full`=1, and it loads the latch with that row.
- R3: A read whose bank and row match a valid latch tag leaves every wordline idle. One cycle later it returns the latched word with `rd_done`=1 and `rd_full`=0.
- R4: The address fields are: bank = `addr[10:9]`, row = `addr[8:3]`, word = `addr[2:0]`. The latch tag holds bank and row, so the same row number in another bank is a miss.
- R5: Reading all eight words of one row in turn gives exactly one full read and seven low-energy reads.
- R6: `rd_done` is high for exactly the one cycle after each accepted read, and low after any cycle with no accepted read.
- R7: A write stores `wdata` at the addressed word. The other seven words of that row keep their values.
- R8: A write to the latched row also updates the latch. A later read of that word is low-energy and returns the new data.
- R9: While `pwr_down` is high, the latch is emptied and any read or write in that cycle is ignored. The next read is a full read.
- R10: When `rd_en` and `wr_en` are high together, the write is performed and the read is ignored, so no `rd_done` pulse follows.
- R11: `rdata` holds the last returned word until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request for `addr` |
| wr_en | input | 1 | Write request of `wdata` to `addr` |
| pwr_down | input | 1 | Power-down request; empties the latch |
| addr | input | 11 | Word address: bank, row, word |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read word, registered |
| rd_done | output | 1 | One-cycle pulse after each accepted read |
| rd_full | output | 1 | With `rd_done`: 1 = full array read, 0 = low-energy read |

## Verification
The hardest case to reach from the ports is a write that lands in the row already held in the latch, followed by a low-energy read of the same word. Only that sequence shows whether the latched copy follows the array. The stimulus first reads a row to fill the latch, then writes one word of that row and reads it back. It expects new data with `rd_full` low, and then reads a neighbouring word to confirm it was not changed. Power-down and a read colliding with a write are placed right after a row has been latched, so that a hit that was wrongly kept would show up as a low `rd_full` flag.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int DEF_ADDR_W = 11;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_WPR    = 8;
  localparam int DEF_BANKS  = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_BLOCK = 2'd3
  } rlc_op_e;
endpackage

// File: rtl/rlc_addr_split.sv
module rlc_addr_split #(
  parameter int ADDR_W = 11,
  parameter int WSEL_W = 3,
  parameter int BANK_W = 2,
  localparam int ROW_W = ADDR_W - WSEL_W - BANK_W,
  localparam int TAG_W = BANK_W + ROW_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [WSEL_W-1:0] word,
  output logic [TAG_W-1:0]  tag
);
  function automatic logic [BANK_W-1:0] f_bank(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] f_row(input logic [ADDR_W-1:0] a);
    return a[WSEL_W +: ROW_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[WSEL_W-1:0];
  endfunction

  assign bank = f_bank(addr);
  assign row  = f_row(addr);
  assign word = f_word(addr);
  assign tag  = {bank, row};
endmodule

// File: rtl/rlc_row_array.sv
module rlc_row_array #(
  parameter int BANKS  = 4,
  parameter int ROWS   = 64,
  parameter int WORD_W = 16,
  parameter int WPR    = 8,
  localparam int BANK_W   = $clog2(BANKS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int WSEL_W   = $clog2(WPR),
  localparam int ROW_BITS = WORD_W * WPR
) (
  input  logic                clk,
  input  logic                rd_fire,
  input  logic                wr_fire,
  input  logic [BANK_W-1:0]   bank,
  input  logic [ROW_W-1:0]    row,
  input  logic [WSEL_W-1:0]   word,
  input  logic [WORD_W-1:0]   wdata,
  output logic [ROW_BITS-1:0] row_out,
  output logic [BANKS-1:0]    wl_bank
);
  logic [ROW_BITS-1:0] bank_row [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_BITS-1:0] mem [ROWS];
    logic                sel;

    assign sel        = (bank == BANK_W'(b));
    assign wl_bank[b] = sel & (rd_fire | wr_fire);
    assign bank_row[b] = (sel & rd_fire) ? mem[row] : '0;

    always_ff @(posedge clk) begin
      if (sel && wr_fire) begin
        for (int w = 0; w < WPR; w++) begin
          if (word == WSEL_W'(w)) mem[row][w*WORD_W +: WORD_W] <= wdata;
        end
      end
    end
  end

  always_comb begin
    row_out = '0;
    for (int b = 0; b < BANKS; b++) row_out = row_out | bank_row[b];
  end
endmodule

// File: rtl/rlc_row_latch.sv
module rlc_row_latch #(
  parameter int WORD_W = 16,
  parameter int WPR    = 8,
  parameter int TAG_W  = 8,
  localparam int WSEL_W   = $clog2(WPR),
  localparam int ROW_BITS = WORD_W * WPR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic [ROW_BITS-1:0] load_row,
  input  logic                upd,
  input  logic [WSEL_W-1:0]   upd_word,
  input  logic [WORD_W-1:0]   upd_data,
  input  logic [WSEL_W-1:0]   rd_word,
  output logic                valid,
  output logic [TAG_W-1:0]    tag,
  output logic [WORD_W-1:0]   word_out
);
  logic [ROW_BITS-1:0] data_q;

  function automatic logic [WORD_W-1:0] pick(input logic [ROW_BITS-1:0] r,
                                             input logic [WSEL_W-1:0]   s);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int w = 0; w < WPR; w++) if (s == WSEL_W'(w)) v = r[w*WORD_W +: WORD_W];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      tag    <= '0;
      data_q <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      tag    <= load_tag;
      data_q <= load_row;
    end else if (upd) begin
      for (int w = 0; w < WPR; w++) begin
        if (upd_word == WSEL_W'(w)) data_q[w*WORD_W +: WORD_W] <= upd_data;
      end
    end
  end

  assign word_out = pick(data_q, rd_word);
endmodule

// File: rtl/rowlatch_rd_ctrl.sv
module rowlatch_rd_ctrl
  import rlc_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int WORD_W = DEF_WORD_W,
  parameter int WPR    = DEF_WPR,
  parameter int BANKS  = DEF_BANKS,
  localparam int WSEL_W   = $clog2(WPR),
  localparam int BANK_W   = $clog2(BANKS),
  localparam int ROW_W    = ADDR_W - WSEL_W - BANK_W,
  localparam int ROWS     = 1 << ROW_W,
  localparam int TAG_W    = BANK_W + ROW_W,
  localparam int ROW_BITS = WORD_W * WPR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              pwr_down,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_done,
  output logic              rd_full
);
  logic [BANK_W-1:0]   a_bank;
  logic [ROW_W-1:0]    a_row;
  logic [WSEL_W-1:0]   a_word;
  logic [TAG_W-1:0]    a_tag;
  logic                lat_valid;
  logic [TAG_W-1:0]    lat_tag;
  logic [WORD_W-1:0]   lat_word;
  logic [ROW_BITS-1:0] arr_row;
  logic [BANKS-1:0]    wl_bank;
  rlc_op_e             op;
  logic                rd_acc, wr_acc, hit, rd_fire, wr_fire, wl_fire;
  logic [WORD_W-1:0]   miss_word;

  function automatic rlc_op_e decode_op(input logic r, input logic w, input logic p);
    if (p)      return OP_BLOCK;
    else if (w) return OP_WRITE;
    else if (r) return OP_READ;
    else        return OP_IDLE;
  endfunction

  function automatic logic [WORD_W-1:0] row_word(input logic [ROW_BITS-1:0] r,
                                                 input logic [WSEL_W-1:0]   s);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int w = 0; w < WPR; w++) if (s == WSEL_W'(w)) v = r[w*WORD_W +: WORD_W];
    return v;
  endfunction

  rlc_addr_split #(.ADDR_W(ADDR_W), .WSEL_W(WSEL_W), .BANK_W(BANK_W)) u_split (
    .addr(addr), .bank(a_bank), .row(a_row), .word(a_word), .tag(a_tag)
  );

  assign op      = decode_op(rd_en, wr_en, pwr_down);
  assign rd_acc  = (op == OP_READ);
  assign wr_acc  = (op == OP_WRITE);
  assign hit     = lat_valid && (lat_tag == a_tag);
  assign rd_fire = rd_acc && !hit;
  assign wr_fire = wr_acc;
  assign wl_fire = |wl_bank;

  rlc_row_array #(.BANKS(BANKS), .ROWS(ROWS), .WORD_W(WORD_W), .WPR(WPR)) u_array (
    .clk(clk), .rd_fire(rd_fire), .wr_fire(wr_fire), .bank(a_bank), .row(a_row),
    .word(a_word), .wdata(wdata), .row_out(arr_row), .wl_bank(wl_bank)
  );

  rlc_row_latch #(.WORD_W(WORD_W), .WPR(WPR), .TAG_W(TAG_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear(pwr_down), .load(rd_fire), .load_tag(a_tag),
    .load_row(arr_row), .upd(wr_acc && hit), .upd_word(a_word), .upd_data(wdata),
    .rd_word(a_word), .valid(lat_valid), .tag(lat_tag), .word_out(lat_word)
  );

  assign miss_word = row_word(arr_row, a_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rd_done <= 1'b0;
      rd_full <= 1'b0;
    end else begin
      rd_done <= rd_acc;
      rd_full <= rd_fire;
      if (rd_acc) rdata <= hit ? lat_word : miss_word;
    end
  end
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_en,
  input logic wr_en,
  input logic pwr_down,
  input logic rd_acc,
  input logic hit,
  input logic wl_fire,
  input logic lat_valid,
  input logic rd_done,
  input logic rd_full
);
  a_r3_hit_wordline_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit) |-> !wl_fire);

  a_r2_miss_fires_wordline: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !hit) |-> wl_fire);

  a_r2_miss_flag_and_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !hit) |=> (rd_full && lat_valid));

  a_r6_done_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_done);

  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_done);

  a_r9_pwrdown_empties: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !lat_valid);

  a_r10_collision_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> !rd_done);

  a_r3_full_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full |-> rd_done);

  a_r9_block_no_wordline: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !wl_fire);
endmodule

bind rowlatch_rd_ctrl rlc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .pwr_down(pwr_down),
  .rd_acc(rd_acc), .hit(hit), .wl_fire(wl_fire), .lat_valid(lat_valid),
  .rd_done(rd_done), .rd_full(rd_full)
);

// File: tb/rowlatch_rd_ctrl_bench.sv
module rowlatch_rd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0, pwr_down = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_done, rd_full;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [2048];

  always #5ns clk = ~clk;

  rowlatch_rd_ctrl u_rowlatch_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .pwr_down(pwr_down),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_done(rd_done), .rd_full(rd_full)
  );

  // {is_write, addr, wdata, expect_full}
  localparam int NVEC = 16;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 11'h000, 16'h0000, 1'b1},  // R1 R2 first read after reset
    {1'b0, 11'h001, 16'h0000, 1'b0},  // R3
    {1'b0, 11'h007, 16'h0000, 1'b0},  // R3
    {1'b0, 11'h008, 16'h0000, 1'b1},  // R4 next row
    {1'b0, 11'h000, 16'h0000, 1'b1},  // R2 back again
    {1'b0, 11'h200, 16'h0000, 1'b1},  // R4 same row, other bank
    {1'b0, 11'h205, 16'h0000, 1'b0},  // R3
    {1'b1, 11'h203, 16'hBEEF, 1'b0},  // R8 write latched row
    {1'b0, 11'h203, 16'h0000, 1'b0},  // R8 new data, low energy
    {1'b0, 11'h204, 16'h0000, 1'b0},  // R7 neighbour unchanged
    {1'b1, 11'h010, 16'h1111, 1'b0},  // R7 write other row
    {1'b0, 11'h206, 16'h0000, 1'b0},  // R3 latch kept
    {1'b0, 11'h010, 16'h0000, 1'b1},  // R7 written word
    {1'b0, 11'h011, 16'h0000, 1'b0},  // R7 neighbour
    {1'b0, 11'h7FF, 16'h0000, 1'b1},  // R4 top bank
    {1'b0, 11'h7F8, 16'h0000, 1'b0}   // R3
  };

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 32'h1234);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[a] = d;
  endtask

  task automatic do_read(input logic [10:0] a, output logic [15:0] d, output logic f,
                         output logic dn);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; f = rd_full; dn = rd_done;
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        f, dn;
    int          fulls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_done", 32'(rd_done), 0);
    check("R1 rd_full", 32'(rd_full), 0);
    check("R1 rdata", 32'(rdata), 0);

    for (int a = 0; a < 2048; a++) do_write(11'(a), pat(a));

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][28]) begin
        do_write(VEC[i][27:17], VEC[i][16:1]);
      end else begin
        do_read(VEC[i][27:17], d, f, dn);
        check($sformatf("R2/R3 vec%0d done", i), 32'(dn), 1);
        check($sformatf("R2/R3 vec%0d data", i), 32'(d), 32'(mdl[VEC[i][27:17]]));
        check($sformatf("R2/R3 vec%0d full", i), 32'(f), 32'(VEC[i][0]));
      end
    end

    // R11 / R6: idle cycles hold data, no pulse
    d = rdata;
    repeat (3) begin
      @(negedge clk);
      check("R11 rdata hold", 32'(rdata), 32'(d));
      check("R6 no pulse idle", 32'(rd_done), 0);
    end

    // R5: whole row in order
    fulls = 0;
    for (int w = 0; w < 8; w++) begin
      do_read(11'h040 + 11'(w), d, f, dn);
      fulls += int'(f);
      check("R5 data", 32'(d), 32'(mdl[11'h040 + 11'(w)]));
    end
    check("R5 full count", 32'(fulls), 1);

    // R9: power-down with read, then with write
    @(negedge clk);
    pwr_down = 1'b1; rd_en = 1'b1; addr = 11'h041;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 read ignored", 32'(rd_done), 0);
    wr_en = 1'b1; wdata = 16'h0F0F; addr = 11'h042;
    @(negedge clk);
    wr_en = 1'b0; pwr_down = 1'b0;
    do_read(11'h042, d, f, dn);
    check("R9 write ignored", 32'(d), 32'(mdl[11'h042]));
    check("R9 full after pwrdown", 32'(f), 1);

    // R10: collision on latched row
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 11'h043; wdata = 16'hCAFE;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    mdl[11'h043] = 16'hCAFE;
    check("R10 no rd_done", 32'(rd_done), 0);
    do_read(11'h043, d, f, dn);
    check("R10 write done", 32'(d), 32'hCAFE);
    check("R8 hit after write", 32'(f), 0);

    // R1: reset mid-run empties latch
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata cleared", 32'(rdata), 0);
    do_read(11'h043, d, f, dn);
    check("R1 first read full", 32'(f), 1);
    check("R1 data kept", 32'(d), 32'hCAFE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule